// File: doc/BRIEF.md
# Subroutine and Coroutine Control Sequencer

This block is the multicycle engine that carries out the control-transfer instructions of a small 8-bit processor: subroutine call, subroutine return and coroutine swap. It owns the program counter and the stack pointer. It reaches a 256-byte memory through one synchronous port that performs at most one read or one write per cycle. The stack lives in that memory and grows toward lower addresses. A push writes the byte below the current stack pointer and then lowers the pointer by one. A pop reads the byte at the pointer and then raises it by one.

The surrounding decoder pulses `start` with a 2-bit command code while the sequencer is idle. The sequencer then steps through its memory accesses and raises `done` for one cycle, by which time `pc` holds the address of the next instruction to fetch. Internally the block moves the PC to "target minus one" and then applies the common end-of-instruction increment, as every other instruction of the processor does. A coroutine swap trades the caller's resume point with the address on top of the stack, so that two routines can hand control back and forth without changing the stack depth.

Top module: `subr_seq`

## Requirements
- R1: Once reset is released, `pc` reads 0x00, `sp` reads 0x00, `done` and `busy` are low, and `mem_re` and `mem_we` are low.
- R2: `opcode` selects the command: 0 = call, 1 = return, 2 = swap. A `start` carrying code 3 is ignored: no memory access, no `done`, and `pc` and `sp` stay unchanged.
- R3: A call reads its target byte at address PC+1, writes PC+2 to address SP-1, lowers `sp` by one, and finishes with `pc` equal to the target.
- R4: A return reads the byte at address SP, raises `sp` by one, and finishes with `pc` equal to that byte.
- R5: A swap reads the byte V at address SP, writes the old PC+1 back to that same address, leaves `sp` as it was, and finishes with `pc` equal to V+1.
- R6: All PC, SP and address arithmetic wraps modulo 256 (for example, a push with `sp` at 0x00 writes address 0xFF).
- R7: `done` is high for exactly one cycle. For a call or a return it follows the 3rd rising clock edge after the edge that accepts `start`. For a swap it follows the 4th. `busy` is high from the accepting edge until `done` rises.
- R8: `start` is ignored while `busy` is high.
- R9: `mem_re` and `mem_we` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, sampled while idle |
| opcode | input | 2 | Command code (0 call, 1 return, 2 swap, 3 reserved) |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| mem_addr | output | 8 | Memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write data |
| pc | output | 8 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after wraparound. It places a call operand at 0xFF so that the link value wraps to 0x00, pushes with the stack pointer at 0x00, and pops at 0xFF. A design without modular arithmetic would write to the wrong address or carry into a ninth bit. It checks a swap reading from a slot that an earlier call wrote, and that the swap's write returns to the same slot. A swap that pushed before popping, or that used the updated pointer, would corrupt the stack and leave `sp` off by one. It also holds `start` high into a busy sequence and issues the reserved code. A sequencer that re-accepted either would restart mid-command and pulse `done` at the wrong time.

// File: rtl/subr_seq_pkg.sv
package subr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_CALL = 2'd0,
    CMD_RET  = 2'd1,
    CMD_SWAP = 2'd2,
    CMD_NONE = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LINK  = 3'd2,
    ST_POP   = 3'd3,
    ST_TAKE  = 3'd4,
    ST_PUSH  = 3'd5,
    ST_FIN   = 3'd6
  } step_e;

endpackage

// File: rtl/subr_seq_ctrl.sv
module subr_seq_ctrl
  import subr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] opcode,
  output step_e      step,
  output cmd_e       cmd,
  output logic       accept,
  output logic       busy,
  output logic       done
);

  step_e step_q, step_d;
  cmd_e  cmd_q;
  logic  done_q, done_d;

  assign accept = (step_q == ST_IDLE) && start && (cmd_e'(opcode) != CMD_NONE);

  always_comb begin
    step_d = step_q;
    done_d = 1'b0;
    case (step_q)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_e'(opcode) == CMD_CALL) step_d = ST_FETCH;
          else                            step_d = ST_POP;
        end
      end
      ST_FETCH: step_d = ST_LINK;
      ST_LINK:  step_d = ST_FIN;
      ST_POP:   step_d = ST_TAKE;
      ST_TAKE:  step_d = (cmd_q == CMD_SWAP) ? ST_PUSH : ST_FIN;
      ST_PUSH:  step_d = ST_FIN;
      ST_FIN: begin
        step_d = ST_IDLE;
        done_d = 1'b1;
      end
      default:  step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      cmd_q  <= CMD_NONE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
      if (accept) cmd_q <= cmd_e'(opcode);
    end
  end

  assign step = step_q;
  assign cmd  = cmd_q;
  assign busy = (step_q != ST_IDLE);
  assign done = done_q;

  // R7: completion pulse lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: leaving busy coincides with done
  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);

  // R8: a start seen while busy does not replace the latched command
  a_r8_busy_holds_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cmd_q));

endmodule

// File: rtl/subr_seq_regs.sv
module subr_seq_regs
  import subr_seq_pkg::*;
#(
  parameter int             W        = 8,
  parameter logic [W-1:0]   RESET_PC = '0,
  parameter logic [W-1:0]   RESET_SP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  step_e        step,
  input  cmd_e         cmd,
  input  logic         accept,
  input  logic         start,
  input  logic [1:0]   opcode,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic [W-1:0] link
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] pc_q, pc_d, sp_q, sp_d, link_q, link_d;
  logic         pc_en, sp_en, link_en;

  always_comb begin
    pc_en   = 1'b0;
    sp_en   = 1'b0;
    link_en = 1'b0;
    pc_d    = pc_q;
    sp_d    = sp_q;
    link_d  = link_q;
    case (step)
      ST_IDLE: begin
        if (accept && cmd_e'(opcode) == CMD_CALL) begin
          pc_en = 1'b1;
          pc_d  = pc_q + ONE;
        end
        if (accept && cmd_e'(opcode) == CMD_SWAP) begin
          link_en = 1'b1;
          link_d  = pc_q + ONE;
        end
      end
      ST_LINK: begin
        pc_en = 1'b1;
        pc_d  = rdata - ONE;
        sp_en = 1'b1;
        sp_d  = sp_q - ONE;
      end
      ST_POP: begin
        sp_en = 1'b1;
        sp_d  = sp_q + ONE;
      end
      ST_TAKE: begin
        pc_en = 1'b1;
        pc_d  = (cmd == CMD_SWAP) ? rdata : (rdata - ONE);
      end
      ST_PUSH: begin
        sp_en = 1'b1;
        sp_d  = sp_q - ONE;
      end
      ST_FIN: begin
        pc_en = 1'b1;
        pc_d  = pc_q + ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      sp_q   <= RESET_SP;
      link_q <= '0;
    end else begin
      if (pc_en)   pc_q   <= pc_d;
      if (sp_en)   sp_q   <= sp_d;
      if (link_en) link_q <= link_d;
    end
  end

  assign pc   = pc_q;
  assign sp   = sp_q;
  assign link = link_q;

  // R6: the stack pointer only ever moves by one, with wrap
  a_r6_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_q != $past(sp_q)) |-> ((sp_q == $past(sp_q) + ONE) || (sp_q == $past(sp_q) - ONE)));

  // R2: the reserved code leaves PC and SP alone
  a_r2_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_IDLE && start && opcode == 2'd3) |=> ($stable(pc_q) && $stable(sp_q)));

endmodule

// File: rtl/subr_seq_port.sv
module subr_seq_port
  import subr_seq_pkg::*;
#(
  parameter int W = 8
) (
  input  step_e        step,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sp,
  input  logic [W-1:0] link,
  output logic [W-1:0] addr,
  output logic         re,
  output logic         we,
  output logic [W-1:0] wdata
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    addr  = '0;
    re    = 1'b0;
    we    = 1'b0;
    wdata = '0;
    case (step)
      ST_FETCH: begin
        re   = 1'b1;
        addr = pc;
      end
      ST_LINK: begin
        we    = 1'b1;
        addr  = sp - ONE;
        wdata = pc + ONE;
      end
      ST_POP: begin
        re   = 1'b1;
        addr = sp;
      end
      ST_PUSH: begin
        we    = 1'b1;
        addr  = sp - ONE;
        wdata = link;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/subr_seq.sv
module subr_seq
  import subr_seq_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] RESET_PC = '0,
  parameter logic [W-1:0] RESET_SP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   opcode,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic         mem_re,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] pc,
  output logic [W-1:0] sp,
  output logic         busy,
  output logic         done
);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  step_e        step;
  cmd_e         cmd;
  logic         accept;
  logic [W-1:0] link;

  subr_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync),
    .start  (start),
    .opcode (opcode),
    .step   (step),
    .cmd    (cmd),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  subr_seq_regs #(.W(W), .RESET_PC(RESET_PC), .RESET_SP(RESET_SP)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync),
    .step   (step),
    .cmd    (cmd),
    .accept (accept),
    .start  (start),
    .opcode (opcode),
    .rdata  (mem_rdata),
    .pc     (pc),
    .sp     (sp),
    .link   (link)
  );

  subr_seq_port #(.W(W)) u_port (
    .step  (step),
    .pc    (pc),
    .sp    (sp),
    .link  (link),
    .addr  (mem_addr),
    .re    (mem_re),
    .we    (mem_we),
    .wdata (mem_wdata)
  );

  // R9: one memory access per cycle at most
  a_r9_single_access: assert property (@(posedge clk) disable iff (!rst_sync)
    !(mem_re && mem_we));

  // R9: the port is quiet while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync)
    !busy |-> !(mem_re || mem_we));

endmodule

// File: tb/subr_seq_tb.sv
module subr_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] opcode = 2'd0;
  logic [7:0] mem_rdata;
  logic [7:0] mem_addr, mem_wdata, pc, sp;
  logic       mem_re, mem_we, busy, done;

  always #4 clk = ~clk;

  subr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .pc(pc), .sp(sp),
    .busy(busy), .done(done)
  );

  logic [7:0] ram   [256];
  logic [7:0] m_mem [256];
  logic [7:0] m_pc, m_sp;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // cycle model of handshake timing (R7, R8)
  int cnt = 0;
  bit exp_done = 0;
  bit checking = 0;

  function automatic int lat(input logic [1:0] op);
    return (op == 2'd2) ? 4 : 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 0;
      exp_done = 0;
    end else begin
      exp_done = (cnt == 1);
      if (cnt > 0) cnt--;
      else if (start && opcode != 2'd3) cnt = lat(opcode);
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      check("R7 done timing", done, exp_done);
      check("R7 busy window", busy, cnt != 0);
      check("R9 single access", mem_re && mem_we, 0);
      if (cnt == 0) check("R9 idle quiet", mem_re || mem_we, 0);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      wrap_up();
    end
  end

  task automatic model_apply(input logic [1:0] op);
    logic [7:0] opnd, v, t;
    case (op)
      2'd0: begin
        opnd = m_pc + 8'd1;
        v = m_mem[opnd];
        m_sp = m_sp - 8'd1;
        m_mem[m_sp] = opnd + 8'd1;
        m_pc = v;
      end
      2'd1: begin
        v = m_mem[m_sp];
        m_sp = m_sp + 8'd1;
        m_pc = v;
      end
      2'd2: begin
        t = m_pc + 8'd1;
        v = m_mem[m_sp];
        m_mem[m_sp] = t;
        m_pc = v + 8'd1;
      end
      default: ;
    endcase
  endtask

  task automatic issue(input logic [1:0] op, input int hold, input string tag);
    @(negedge clk);
    start = 1'b1;
    opcode = op;
    repeat (hold) @(negedge clk);
    start = 1'b0;
    if (op == 2'd3) begin
      repeat (6) @(negedge clk);
      check({tag, " pc kept"}, pc, m_pc);
      check({tag, " sp kept"}, sp, m_sp);
    end else begin
      for (int i = 0; i < 20 && !done; i++) @(negedge clk);
      model_apply(op);
      check({tag, " pc"}, pc, m_pc);
      check({tag, " sp"}, sp, m_sp);
      check({tag, " stack top"}, ram[m_sp], m_mem[m_sp]);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'(i * 37 + 11);
    ram[8'h01] = 8'h40;
    ram[8'h41] = 8'hFE;
    for (int i = 0; i < 256; i++) m_mem[i] = ram[i];
    m_pc = 8'h00;
    m_sp = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: state after reset
    check("R1 pc reset", pc, 8'h00);
    check("R1 sp reset", sp, 8'h00);
    check("R1 done low", done, 0);
    check("R1 busy low", busy, 0);
    check("R1 port quiet", mem_re || mem_we, 0);
    checking = 1;
    issue(2'd0, 1, "R3 R6 call push at wrapped sp");
    issue(2'd0, 2, "R8 call with start held into busy");
    issue(2'd0, 1, "R6 call with operand at 0xFF");
    issue(2'd2, 1, "R5 swap");
    issue(2'd3, 1, "R2 reserved code");
    issue(2'd1, 1, "R4 return");
    issue(2'd1, 1, "R4 return second");
    issue(2'd1, 1, "R6 return pop wraps sp");
    issue(2'd2, 1, "R5 R6 swap at sp 0");
    issue(2'd0, 1, "R3 call again");
    issue(2'd1, 1, "R4 return after call");
    begin
      int diffs = 0;
      for (int i = 0; i < 256; i++) if (ram[i] !== m_mem[i]) diffs++;
      check("R3 R4 R5 whole memory", diffs, 0);
    end
    checking = 0;
    wrap_up();
  end

endmodule